// File: doc/BRIEF.md
# Two-Level Cascaded DMA Channel Arbiter

This block picks which of seven DMA request lines is served next. The channels sit in two groups of four. One group is the lower tier: its combined demand appears as a hold request. That hold request becomes channel 0 of the upper tier, whose other three slots are ordinary device channels. When the upper tier picks its cascade slot, the hold is acknowledged and the lower tier's own winner receives the grant. Each tier is set on its own to fixed order or to rotating order. In rotating order the channel served last drops to the bottom.

A grant, once issued, stays in place until the system reports the end of the transfer with a one-cycle done pulse. The arbiter then spends one idle cycle and re-evaluates the requests on the next clock edge. Requests that appear or vanish while a grant is held do not disturb it. The rotation history of a tier moves only when a transfer that the tier served is completed.

Top module: `cascade_prio_arb`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `grant_o`, `ack_o` and `hold_o` are 0, and both tiers use fixed order.
- R2: `grant_o` is one-hot or zero. When idle with at least one request, a grant appears on the next clock edge and goes only to a channel whose request was high at that edge.
- R3: A grant is held until `done_i` is sampled high. At that edge it clears, and the next grant can appear no earlier than the following edge. A `done_i` pulse while idle has no effect.
- R4: The grant bits are numbered as follows. Bits 0 to 3 are lower-tier channels 0 to 3, and bits 4 to 6 are upper-tier channels 1 to 3. With both tiers fixed, priority runs from bit 0 down to bit 6.
- R5: When `rot_sec_i` = 1, the lower-tier channel served last becomes lowest priority, and the next channel after it (wrapping) becomes highest.
- R6: When `rot_pri_i` = 1, the upper tier rotates the same way over its cascade slot and its channels 1 to 3. A completed lower-tier transfer counts as service of the cascade slot.
- R7: A tier's rotation history changes only on a completed transfer that it served. A completion under fixed order resets that history, so that after a switch to rotating order channel 0 is highest.
- R8: `ack_o` (the cascade acknowledge) is high exactly while a lower-tier channel holds the grant.
- R9: `hold_o` is high on the cycle after any lower-tier request is sampled high, and also while a lower-tier grant is held.
- R10: While a grant is held, no request of any priority pre-empts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 7 | Request lines, bit numbering as in R4 |
| rot_sec_i | input | 1 | Lower tier order: 1 rotating, 0 fixed |
| rot_pri_i | input | 1 | Upper tier order: 1 rotating, 0 fixed |
| done_i | input | 1 | One-cycle end-of-transfer pulse |
| grant_o | output | 7 | One-hot grant, bit numbering as in R4 |
| ack_o | output | 1 | Cascade acknowledge to the lower tier |
| hold_o | output | 1 | Lower tier hold request |

## Verification
The completion of a transfer and the arrival of a new request, including one of higher priority, can fall in the same cycle. A completion can also coincide with a change of the tier order bit. The bench raises `done_i` on the very negedge where it changes `req_i` or a mode bit. It then expects the grant to clear on that edge with no new grant. On the following edge the grant must reflect the new requests and the order in force after the history update.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  // Channels per tier; the upper tier spends one slot on the cascade.
  localparam int CPA_GRP_CH = 4;

  function automatic int cpa_total_ch(input int grp_ch);
    return 2 * grp_ch - 1;
  endfunction
endpackage

// File: rtl/arb_prio_group.sv
// One tier of the arbiter: fixed or rotating order over GRP_CH requests.
module arb_prio_group #(
  parameter int GRP_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [GRP_CH-1:0]         req,
  input  logic                      rotate,
  input  logic                      upd,
  input  logic [$clog2(GRP_CH)-1:0] upd_idx,
  output logic                      win_valid,
  output logic [$clog2(GRP_CH)-1:0] win_idx
);
  localparam int IW = $clog2(GRP_CH);
  localparam logic [IW-1:0] LAST = IW'(GRP_CH - 1);

  logic [IW-1:0] last_q;
  logic [IW-1:0] start;
  logic [IW-1:0] cand;

  // History of the most recently served channel; reset when served in fixed order.
  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= LAST;
    end else if (upd) begin
      last_q <= rotate ? upd_idx : LAST;
    end
  end

  // Search starts just after the last served channel (wraps, GRP_CH is a power of two).
  always_comb begin
    start     = rotate ? last_q + IW'(1) : '0;
    win_valid = 1'b0;
    win_idx   = '0;
    cand      = '0;
    for (int k = 0; k < GRP_CH; k++) begin
      cand = start + IW'(k);
      if (!win_valid && req[cand]) begin
        win_valid = 1'b1;
        win_idx   = cand;
      end
    end
  end
endmodule

// File: rtl/arb_grant_ctrl.sv
// Holds the grant until the done pulse and produces the cascade handshake.
module arb_grant_ctrl #(
  parameter int GRP_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      done_i,
  input  logic                      pri_valid,
  input  logic [$clog2(GRP_CH)-1:0] pri_idx,
  input  logic [$clog2(GRP_CH)-1:0] sec_idx,
  input  logic                      sec_any,
  output logic [2*GRP_CH-2:0]       grant_o,
  output logic                      ack_o,
  output logic                      hold_o,
  output logic                      upd_pri_o,
  output logic                      upd_sec_o,
  output logic [$clog2(GRP_CH)-1:0] pri_srv_o,
  output logic [$clog2(GRP_CH)-1:0] sec_srv_o
);
  localparam int IW  = $clog2(GRP_CH);
  localparam int TOT = 2 * GRP_CH - 1;

  logic          busy_q;
  logic [IW-1:0] pri_q;
  logic [IW-1:0] sec_q;
  logic          start;
  logic          finish;
  logic          sec_hold_nxt;
  logic [TOT-1:0] gvec;

  assign start  = !busy_q && pri_valid;
  assign finish = busy_q && done_i;

  // Map the tier winners onto the flat grant vector.
  always_comb begin
    gvec = '0;
    for (int i = 0; i < TOT; i++) begin
      if (i < GRP_CH) begin
        gvec[i] = (pri_idx == '0) && (sec_idx == IW'(i));
      end else begin
        gvec[i] = (pri_idx == IW'(i - GRP_CH + 1));
      end
    end
  end

  assign sec_hold_nxt = start ? (pri_idx == '0)
                              : (busy_q && !done_i && (pri_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      pri_q   <= '0;
      sec_q   <= '0;
      grant_o <= '0;
      ack_o   <= 1'b0;
      hold_o  <= 1'b0;
    end else begin
      if (start) begin
        busy_q  <= 1'b1;
        pri_q   <= pri_idx;
        sec_q   <= sec_idx;
        grant_o <= gvec;
        ack_o   <= (pri_idx == '0);
      end else if (finish) begin
        busy_q  <= 1'b0;
        grant_o <= '0;
        ack_o   <= 1'b0;
      end
      hold_o <= sec_any | sec_hold_nxt;
    end
  end

  assign upd_pri_o = finish;
  assign upd_sec_o = finish && (pri_q == '0);
  assign pri_srv_o = pri_q;
  assign sec_srv_o = sec_q;
endmodule

// File: rtl/cascade_prio_arb.sv
module cascade_prio_arb
  import cpa_pkg::*;
#(
  parameter int GRP_CH = CPA_GRP_CH
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2*GRP_CH-2:0]     req_i,
  input  logic                    rot_sec_i,
  input  logic                    rot_pri_i,
  input  logic                    done_i,
  output logic [2*GRP_CH-2:0]     grant_o,
  output logic                    ack_o,
  output logic                    hold_o
);
  localparam int IW  = $clog2(GRP_CH);
  localparam int TOT = cpa_total_ch(GRP_CH);

  logic [GRP_CH-1:0] sec_req;
  logic [GRP_CH-1:0] pri_req;
  logic              sec_valid;
  logic [IW-1:0]     sec_idx;
  logic              pri_valid;
  logic [IW-1:0]     pri_idx;
  logic              upd_pri;
  logic              upd_sec;
  logic [IW-1:0]     pri_srv;
  logic [IW-1:0]     sec_srv;

  assign sec_req = req_i[GRP_CH-1:0];
  // Upper tier slot 0 is the lower tier's combined demand.
  assign pri_req = {req_i[TOT-1:GRP_CH], sec_valid};

  arb_prio_group #(.GRP_CH(GRP_CH)) u_sec (
    .clk(clk), .rst(rst), .req(sec_req), .rotate(rot_sec_i),
    .upd(upd_sec), .upd_idx(sec_srv),
    .win_valid(sec_valid), .win_idx(sec_idx)
  );

  arb_prio_group #(.GRP_CH(GRP_CH)) u_pri (
    .clk(clk), .rst(rst), .req(pri_req), .rotate(rot_pri_i),
    .upd(upd_pri), .upd_idx(pri_srv),
    .win_valid(pri_valid), .win_idx(pri_idx)
  );

  arb_grant_ctrl #(.GRP_CH(GRP_CH)) u_ctrl (
    .clk(clk), .rst(rst), .done_i(done_i),
    .pri_valid(pri_valid), .pri_idx(pri_idx), .sec_idx(sec_idx),
    .sec_any(sec_valid),
    .grant_o(grant_o), .ack_o(ack_o), .hold_o(hold_o),
    .upd_pri_o(upd_pri), .upd_sec_o(upd_sec),
    .pri_srv_o(pri_srv), .sec_srv_o(sec_srv)
  );
endmodule

// File: rtl/cascade_prio_arb_chk.sv
module cascade_prio_arb_chk #(
  parameter int GRP_CH = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [2*GRP_CH-2:0] req_i,
  input logic                done_i,
  input logic [2*GRP_CH-2:0] grant_o,
  input logic                ack_o,
  input logic                hold_o
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (rst)
    (grant_o == '0) |=> ((grant_o == '0) || ((grant_o & $past(req_i)) != '0)));

  assert_grant_kept_R3: assert property (@(posedge clk) disable iff (rst)
    ((grant_o != '0) && !done_i) |=> (grant_o == $past(grant_o)));

  assert_grant_release_R3: assert property (@(posedge clk) disable iff (rst)
    ((grant_o != '0) && done_i) |=> (grant_o == '0));

  assert_ack_match_R8: assert property (@(posedge clk) disable iff (rst)
    ack_o == (grant_o[GRP_CH-1:0] != '0));

  assert_hold_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (req_i[GRP_CH-1:0] != '0) |=> hold_o);
endmodule

bind cascade_prio_arb cascade_prio_arb_chk #(.GRP_CH(GRP_CH)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .done_i(done_i),
  .grant_o(grant_o), .ack_o(ack_o), .hold_o(hold_o)
);

// File: tb/sim_cascade_prio_arb.sv
`timescale 1ns/1ps
module sim_cascade_prio_arb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] req = '0;
  logic       rot_sec = 1'b0;
  logic       rot_pri = 1'b0;
  logic       done = 1'b0;
  logic [6:0] grant;
  logic       ack;
  logic       hold;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cascade_prio_arb u0 (
    .clk(clk), .rst(rst), .req_i(req), .rot_sec_i(rot_sec), .rot_pri_i(rot_pri),
    .done_i(done), .grant_o(grant), .ack_o(ack), .hold_o(hold)
  );

  task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Grant currently checked; pulse done, verify the idle cycle, then step to next grant.
  task automatic finish_xfer(input logic [6:0] next_req);
    done = 1'b1;
    step();
    done = 1'b0;
    req = next_req;
    chk("R3 idle gap", grant, 7'h00);
    step();
  endtask

  task automatic t_reset();
    step();
    chk("R1 grant", grant, 7'h00);
    chk("R1 ack", {6'd0, ack}, 7'h00);
    chk("R1 hold", {6'd0, hold}, 7'h00);
    rst = 1'b0;
    step();
    chk("R1 grant after", grant, 7'h00);
  endtask

  task automatic t_fixed();
    logic [6:0] r;
    r = 7'h7F;
    req = r;
    step();
    for (int b = 0; b < 7; b++) begin
      chk("R4 fixed order", grant, 7'(1 << b));
      chk("R8 ack", {6'd0, ack}, {6'd0, (b < 4)});
      r[b] = 1'b0;
      finish_xfer(r);
    end
    chk("R2 no request", grant, 7'h00);
  endtask

  task automatic t_sec_rot();
    rot_sec = 1'b1;
    req = 7'h0F;
    step();
    chk("R5 first", grant, 7'h01);
    finish_xfer(7'h0F);
    chk("R5 rot1", grant, 7'h02);
    finish_xfer(7'h0F);
    chk("R5 rot2", grant, 7'h04);
    finish_xfer(7'h0F);
    chk("R5 rot3", grant, 7'h08);
    finish_xfer(7'h0F);
    chk("R5 wrap", grant, 7'h01);
    rot_sec = 1'b0;
    finish_xfer(7'h00);
  endtask

  task automatic t_pri_rot();
    rot_pri = 1'b1;
    req = 7'b1110001;
    step();
    chk("R6 cascade", grant, 7'h01);
    chk("R8 ack cascade", {6'd0, ack}, 7'h01);
    finish_xfer(7'b1110001);
    chk("R6 ch5", grant, 7'h10);
    finish_xfer(7'b1110001);
    chk("R6 ch6", grant, 7'h20);
    finish_xfer(7'b1110001);
    chk("R6 ch7", grant, 7'h40);
    finish_xfer(7'b1110001);
    chk("R6 wrap cascade", grant, 7'h01);
    rot_pri = 1'b0;
    finish_xfer(7'h00);
  endtask

  task automatic t_history();
    rot_sec = 1'b1;
    req = 7'h02;
    step();
    chk("R7 serve ch1", grant, 7'h02);
    finish_xfer(7'h00);
    done = 1'b1;
    step();
    done = 1'b0;
    step();
    chk("R3 idle done ignored", grant, 7'h00);
    req = 7'h0F;
    step();
    chk("R7 idle done no rotate", grant, 7'h04);
    done = 1'b1;
    step();
    done = 1'b0;
    rot_sec = 1'b0;
    chk("R3 idle gap", grant, 7'h00);
    step();
    chk("R7 fixed after switch", grant, 7'h01);
    done = 1'b1;
    step();
    done = 1'b0;
    rot_sec = 1'b1;
    chk("R3 idle gap", grant, 7'h00);
    step();
    chk("R7 history reset", grant, 7'h01);
    rot_sec = 1'b0;
    finish_xfer(7'h00);
  endtask

  task automatic t_hold_preempt();
    req = 7'h40;
    step();
    chk("R10 low grant", grant, 7'h40);
    req = 7'h01;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R10 no preempt", grant, 7'h40);
    end
    chk("R9 hold pending", {6'd0, hold}, 7'h01);
    // done and a new request land together
    done = 1'b1;
    req = 7'h11;
    step();
    done = 1'b0;
    chk("R3 clear with new req", grant, 7'h00);
    step();
    chk("R4 new grant", grant, 7'h01);
    req = 7'h00;
    step();
    chk("R9 hold while granted", {6'd0, hold}, 7'h01);
    chk("R8 ack held", {6'd0, ack}, 7'h01);
    done = 1'b1;
    step();
    done = 1'b0;
    chk("R9 hold drops", {6'd0, hold}, 7'h00);
    chk("R8 ack drops", {6'd0, ack}, 7'h00);
    step();
    chk("R2 idle", grant, 7'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=%h exp=%h", 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_fixed();
    t_sec_rot();
    t_pri_rot();
    t_history();
    t_hold_preempt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule